// File: doc/BRIEF.md
# Reset-Synchronized Three-Phase PWM Generator

This block drives a three-phase bridge from one up-counter. The counter climbs from zero to a programmable period value and returns to zero on the next count. Each of three phases has its own compare register. A phase turns active on its compare match and returns to its idle level on the period match, so every phase edge is tied to the shared period restart. Each phase has a positive pin and a complementary negative pin. A separate cycle-sync pin flips once per period.

Software programs the block through a simple write port. The addresses hold a control word (start bit, 4-bit mode, prescaler select, two polarity bits and a sync enable), the period, three compare values, a six-bit pin enable mask and a counter load. The intended sequence is as follows. Halt the counter, load it with zero, program the period, compares, enables and mode, then set the start bit.

Top module: `rsync_pwm`

## Requirements
- R1: While running, the counter advances by one on each prescaler tick. When it equals the period value it goes to zero on the next tick, so it visits 0..P.
- R2: The prescaler select field (control bits 6:5) gives one tick every 1, 4, 16 or 64 clocks for the values 0, 1, 2 or 3.
- R3: The raw positive phase i is active while the counter lies in cmp_i+1..P and inactive at count zero. A compare of zero, or one above the period, never makes the phase active.
- R4: A compare equal to the period makes the phase toggle at each period match. The output then has a cycle of two periods and changes state once per period.
- R5: Each negative pin carries the complement of its phase's positive state before polarity is applied.
- R6: Control bit 7 inverts all positive pins and control bit 8 inverts all negative pins. A value of 0 means active high.
- R7: Enable mask bits 0..2 gate the positive pins of phases 0..2 and bits 3..5 gate the negative pins. A disabled pin sits at its inactive level, which equals its polarity bit.
- R8: The outputs work only when the mode field (control bits 4:1) holds binary 1000. With any other value every PWM pin sits at its inactive level and the sync pin is 0.
- R9: With control bit 9 set, the sync pin starts at 0 and flips at every period match. With the bit clear, the sync pin is 0.
- R10: While running (control bit 0 set), writes to the mode field, the prescaler field and the counter load (address 6) are ignored. Addresses: 0 control, 1 period, 2..4 compares, 5 enable mask.
- R11: After reset the counter is 0, all registers are 0, every PWM pin is 0 and the sync pin is 0.
- R12: While halted the counter holds its value, every raw phase is inactive and the sync state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| pwm_p_o | output | 3 | Positive-phase pins, one per phase |
| pwm_n_o | output | 3 | Negative-phase pins, one per phase |
| sync_o | output | 1 | Cycle-sync toggle pin |

## Verification
The assertions assume the counter is loaded only while halted and never holds a value above the period. If it did, the wrap and step checks would watch a counter running toward overflow. The sync-flip check also assumes no control write lands in the same cycle as a period match. The bench keeps to these assumptions. Every scenario halts the block, loads the counter with zero, programs a period and then starts it. Writes made while running target only the locked fields, or a counter value that the locked load must reject.

// File: rtl/rsync_pwm.sv
module rsync_pwm #(
  parameter int CW  = 16,
  parameter int NPH = 3,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [CW-1:0]  count_o,
  output logic [NPH-1:0] pwm_p_o,
  output logic [NPH-1:0] pwm_n_o,
  output logic           sync_o
);
  localparam int OEW   = 2 * NPH;
  localparam int A_CMP = 2;
  localparam int A_OE  = A_CMP + NPH;
  localparam int A_CNT = A_OE + 1;
  localparam int PW    = 6;
  localparam logic [3:0] MODE_PWM = 4'b1000;

  logic           run_q, pol_p, pol_n, sync_en, sync_q;
  logic [3:0]     mode_q;
  logic [1:0]     psel_q;
  logic [CW-1:0]  per_q, cnt_q;
  logic [OEW-1:0] oe_q;
  logic [PW-1:0]  pre_q, pre_lim;
  logic [NPH-1:0] ph;
  logic           tick, wrap, mode_ok;

  wire wr_ctrl = wr_en && wr_addr == AW'(0);

  assign mode_ok = mode_q == MODE_PWM;
  assign pre_lim = (PW'(1) << {psel_q, 1'b0}) - PW'(1);
  assign tick    = run_q && pre_q == pre_lim;
  assign wrap    = cnt_q == per_q;
  assign count_o = cnt_q;
  assign sync_o  = sync_q & sync_en & mode_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q <= 1'b0; mode_q <= '0; psel_q <= '0;
      pol_p <= 1'b0; pol_n <= 1'b0; sync_en <= 1'b0;
    end else if (wr_ctrl) begin
      run_q   <= wr_data[0];
      pol_p   <= wr_data[7];
      pol_n   <= wr_data[8];
      sync_en <= wr_data[9];
      if (!run_q) begin
        mode_q <= wr_data[4:1];
        psel_q <= wr_data[6:5];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_q <= '0; oe_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(1))    per_q <= wr_data;
      if (wr_addr == AW'(A_OE)) oe_q  <= wr_data[OEW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  pre_q <= '0;
    else if (!run_q || tick)     pre_q <= '0;
    else                         pre_q <= pre_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt_q <= '0;
    else if (!run_q) begin
      if (wr_en && wr_addr == AW'(A_CNT)) cnt_q <= wr_data;
    end else if (tick)
      cnt_q <= wrap ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         sync_q <= 1'b0;
    else if (!run_q || !sync_en)        sync_q <= 1'b0;
    else if (tick && wrap)              sync_q <= ~sync_q;

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    logic [CW-1:0] cmp_q;
    logic          hit;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                   cmp_q <= '0;
      else if (wr_en && wr_addr == AW'(A_CMP + i))  cmp_q <= wr_data;

    assign hit = cnt_q == cmp_q && cmp_q != '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                    ph[i] <= 1'b0;
      else if (!run_q || !mode_ok)   ph[i] <= 1'b0;
      else if (tick) begin
        if (wrap)      ph[i] <= hit ? ~ph[i] : 1'b0;
        else if (hit)  ph[i] <= 1'b1;
      end

    assign pwm_p_o[i] = (mode_ok & oe_q[i]       &  ph[i]) ^ pol_p;
    assign pwm_n_o[i] = (mode_ok & oe_q[NPH + i] & ~ph[i]) ^ pol_n;
  end
endmodule

module rsync_pwm_chk #(
  parameter int CW  = 16,
  parameter int NPH = 3,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [CW-1:0]  count_o,
  input logic [NPH-1:0] pwm_p_o,
  input logic [NPH-1:0] pwm_n_o,
  input logic           sync_o,
  input logic           tick,
  input logic           run_q,
  input logic [CW-1:0]  per_q,
  input logic           mode_ok,
  input logic           sync_en,
  input logic           pol_p,
  input logic           pol_n,
  input logic [2*NPH-1:0] oe_q
);
  localparam logic [AW-1:0] A_CNT = AW'(NPH + 3);

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count_o == per_q |=> count_o == '0);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count_o < per_q |=> count_o == $past(count_o) + CW'(1));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !(wr_en && wr_addr == A_CNT) |=> $stable(count_o));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> !sync_o && pwm_p_o == {NPH{pol_p}} && pwm_n_o == {NPH{pol_n}});

  p_comp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok && &oe_q |-> (pwm_p_o ^ {NPH{pol_p}}) == ~(pwm_n_o ^ {NPH{pol_n}}));

  p_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count_o == per_q && sync_en && mode_ok && !wr_en |=> sync_o != $past(sync_o));
endmodule

bind rsync_pwm rsync_pwm_chk #(.CW(CW), .NPH(NPH), .AW(AW)) u_chk (.*);

// File: tb/rsync_pwm_test.sv
module rsync_pwm_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic [2:0]  pwm_p_o, pwm_n_o;
  logic        sync_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  rsync_pwm uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctl(input int run, input int mode, input int ps,
                             input int pp, input int pn, input int se);
    return run | (mode << 1) | (ps << 5) | (pp << 7) | (pn << 8) | (se << 9);
  endfunction

  task automatic setup(input int per, input int c0, input int c1, input int c2,
                       input int ps, input int pp, input int pn, input int se,
                       input int mode, input int oe);
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(6, 0);
    wr(1, per); wr(2, c0); wr(3, c1); wr(4, c2); wr(5, oe);
    wr(0, ctl(0, mode, ps, pp, pn, se));
    wr(0, ctl(1, mode, ps, pp, pn, se));
  endtask

  function automatic bit exp_ph(input int cnt, input int c, input int per);
    return (c != 0 && c < per) ? (cnt > c) : 1'b0;
  endfunction

  task automatic wait_count(input int v);
    for (int k = 0; k < 2000 && count_o != 16'(v); k++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 count", int'(count_o), 0);
    chk("R11 pins", int'({pwm_p_o, pwm_n_o, sync_o}), 0);
  endtask

  task automatic t_count;
    int bad = 0, wraps = 0, prev;
    setup(7, 0, 0, 0, 0, 0, 0, 0, 8, 63);
    prev = int'(count_o);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (prev == 7 && count_o == 0) wraps++;
      else if (int'(count_o) != prev + 1) bad++;
      prev = int'(count_o);
    end
    chk("R1 step errors", bad, 0);
    chk("R1 wraps seen", wraps > 0 ? 1 : 0, 1);
  endtask

  task automatic t_prescale;
    for (int ps = 1; ps < 4; ps++) begin
      int gap = 0;
      logic [15:0] v;
      setup(50, 0, 0, 0, ps, 0, 0, 0, 8, 63);
      v = count_o;
      while (count_o == v) @(negedge clk);
      v = count_o;
      while (count_o == v && gap < 200) begin @(negedge clk); gap++; end
      chk("R2 tick spacing", gap, 1 << (2 * ps));
    end
  endtask

  task automatic t_duty;
    int bad = 0, badn = 0;
    setup(9, 3, 0, 12, 0, 0, 0, 0, 8, 63);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pwm_p_o != {exp_ph(count_o, 12, 9), exp_ph(count_o, 0, 9), exp_ph(count_o, 3, 9)}) bad++;
      if (pwm_n_o != ~pwm_p_o) badn++;
    end
    chk("R3 phase vs count", bad, 0);
    chk("R5 negative complement", badn, 0);
  endtask

  task automatic t_equal;
    setup(5, 5, 0, 0, 0, 0, 0, 0, 8, 63);
    for (int p = 0; p < 3; p++) begin
      wait_count(2);
      chk("R4 toggle per period", int'(pwm_p_o[0]), p % 2);
      @(negedge clk);
    end
  endtask

  task automatic t_polarity;
    int bad = 0;
    setup(9, 3, 5, 7, 0, 1, 1, 0, 8, 63);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_p_o != ~{exp_ph(count_o, 7, 9), exp_ph(count_o, 5, 9), exp_ph(count_o, 3, 9)}) bad++;
      if (pwm_n_o != {exp_ph(count_o, 7, 9), exp_ph(count_o, 5, 9), exp_ph(count_o, 3, 9)}) bad++;
    end
    chk("R6 inverted pins", bad, 0);
  endtask

  task automatic t_enable;
    int bad0 = 0, badn1 = 0;
    setup(9, 3, 3, 3, 0, 1, 0, 0, 8, 6'b101110);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_p_o[0] != 1'b1) bad0++;
      if (pwm_n_o[1] != 1'b0) badn1++;
    end
    chk("R7 disabled positive pin", bad0, 0);
    chk("R7 disabled negative pin", badn1, 0);
  endtask

  task automatic t_mode;
    int bad = 0, moved = 0;
    setup(9, 3, 4, 5, 0, 0, 0, 1, 0, 63);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if ({pwm_p_o, pwm_n_o, sync_o} != 7'd0) bad++;
      if (count_o != 0) moved = 1;
    end
    chk("R8 pins idle in other mode", bad, 0);
    chk("R8 counter still runs", moved, 1);
  endtask

  task automatic t_sync;
    int bad = 0;
    setup(4, 2, 0, 0, 0, 0, 0, 1, 8, 63);
    for (int p = 0; p < 3; p++) begin
      wait_count(2);
      chk("R9 sync flips per period", int'(sync_o), p % 2);
      @(negedge clk);
    end
    setup(4, 2, 0, 0, 0, 0, 0, 0, 8, 63);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (sync_o) bad++;
    end
    chk("R9 sync off when disabled", bad, 0);
  endtask

  task automatic t_lock;
    int bad = 0, over = 0, prev, step = 0;
    setup(9, 3, 0, 0, 0, 0, 0, 0, 8, 63);
    wr(0, ctl(1, 0, 3, 0, 0, 0));
    wr(6, 16'h55);
    prev = int'(count_o);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_p_o[0] != exp_ph(count_o, 3, 9)) bad++;
      if (count_o > 9) over++;
      if (!(int'(count_o) == prev + 1 || (prev == 9 && count_o == 0))) step++;
      prev = int'(count_o);
    end
    chk("R10 mode locked while running", bad, 0);
    chk("R10 counter load ignored", over, 0);
    chk("R10 prescaler locked", step, 0);
  endtask

  task automatic t_halt;
    logic [15:0] v;
    int bad = 0;
    setup(9, 2, 2, 2, 0, 0, 0, 1, 8, 63);
    wait_count(6);
    wr(0, ctl(0, 8, 0, 0, 0, 1));
    v = count_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (count_o != v) bad++;
      if (pwm_p_o != 3'b000 || pwm_n_o != 3'b111 || sync_o) bad++;
    end
    chk("R12 halted hold and idle", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count;
    t_prescale;
    t_duty;
    t_equal;
    t_polarity;
    t_enable;
    t_mode;
    t_sync;
    t_lock;
    t_halt;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule